// File: doc/BRIEF.md
# Stop-Mode Power Sequencer

This block moves a processor core into a clock-stopped low-power state and brings it back out. Software starts the entry by writing a control word that carries a stop request and a pin-float choice. The entry is refused when an enabled interrupt is already pending. Once stopped, the oscillator enable and the core clock gate are both low. Register and RAM contents are kept simply because no clock reaches them. External pins either keep their last drive or float, as the control word chose. Bus hold requests get no acknowledge while the core is out of its run state.

The block leaves stop on an external reset request or on any interrupt whose 3-bit level is not all ones. Level 7 means "no enabled request". It first turns the oscillator back on and waits for a settling interval chosen by a 2-bit select. Only after that wait does it reopen the core clock. In the last settling cycle it pulses either a reset-sequence start or an interrupt wake indication, depending on what woke it.

The states are RUN (status 00), STOPPING (01), STOPPED (10) and SETTLE (11). The transitions are:
- RUN to STOPPING on an accepted write.
- STOPPING to STOPPED, or to SETTLE if a wake cause is already present.
- STOPPED to SETTLE on a wake cause.
- SETTLE to RUN when the interval ends.

Top module: `stopmode_ctl`

## Requirements
- R1: Out of reset, status is 00 (RUN), osc_en and core_clk_en are 1, and pin_hiz, hold_ack, stop_bit, wake_irq and reset_seq_start are 0.
- R2: In RUN, a write with ctl_stop_bit=1 while irq_level is 7 sets status to 01 in the next cycle, with core_clk_en=0 and stop_bit=1. The cycle after that, status is 10 (STOPPED) with osc_en=0.
- R3: In RUN, a write with ctl_stop_bit=1 while irq_level is not 7 is refused: status stays 00 and stop_bit stays 0.
- R4: pin_hiz is 0 in RUN. Outside RUN it equals the ctl_pin_hiz_bit value captured with the accepted stop write.
- R5: In RUN, hold_ack follows hold_req one cycle later. Outside RUN, hold_ack is 0 whatever hold_req does.
- R6: In STOPPED, irq_level=7 with ext_reset_req=0 keeps status at 10.
- R7: In STOPPED, irq_level other than 7, or ext_reset_req=1, gives status 11 (SETTLE) in the next cycle with osc_en=1 and core_clk_en=0.
- R8: SETTLE lasts exactly 2^SHIFTn cycles, where n is the wait_sel code sampled in the cycle before SETTLE begins. The default shifts for codes 0, 1, 2 and 3 are 10, 13, 15 and 17. Changes to wait_sel during SETTLE have no effect.
- R9: If ext_reset_req caused the wake, was present together with an interrupt at wake, or arrived at any point during SETTLE, reset_seq_start is 1 in the last SETTLE cycle and wake_irq stays 0.
- R10: After a wake caused only by an interrupt, wake_irq is 1 in the last SETTLE cycle. The next cycle is RUN with core_clk_en=1 and stop_bit=0.
- R11: A write with ctl_stop_bit=0, or any write outside RUN, changes neither status nor pin_hiz.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-running reference clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| ctl_wr | input | 1 | Control word write strobe |
| ctl_stop_bit | input | 1 | Stop request bit of the written word |
| ctl_pin_hiz_bit | input | 1 | 1: pins float during stop; 0: pins hold their drive |
| wait_sel | input | 2 | Settling interval select |
| irq_level | input | 3 | Highest pending interrupt level; 7 means none |
| ext_reset_req | input | 1 | External reset request (wake cause) |
| hold_req | input | 1 | Bus hold request |
| osc_en | output | 1 | Oscillator enable |
| core_clk_en | output | 1 | Core clock gate enable |
| pin_hiz | output | 1 | Float external pins |
| hold_ack | output | 1 | Bus hold acknowledge |
| wake_irq | output | 1 | Interrupt wake indication, one cycle |
| reset_seq_start | output | 1 | Start of reset sequence, one cycle |
| stop_bit | output | 1 | Readback of the self-clearing stop bit |
| status | output | 2 | 00 RUN, 01 STOPPING, 10 STOPPED, 11 SETTLE |

## Verification
The bench targets the following corner cases:
- A stop write made while an interrupt is pending. A design that ignored the pending interrupt would stall a core that has work to do.
- Level 7 held during stop. A design that treated 7 as a request would wake spuriously.
- A reset arriving together with an interrupt, or midway through settling. A design that misjudged this would resume execution when it should restart.
- wait_sel changing during settling. A design that read the select live would release the clock early or late.

A scoreboard compares each wake pulse's kind and the measured settle length against the expected values.

// File: rtl/stopmode_pkg.sv
package stopmode_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [1:0] {
        ST_RUN      = 2'b00,
        ST_STOPPING = 2'b01,
        ST_STOPPED  = 2'b10,
        ST_SETTLE   = 2'b11
    } stop_state_e;

endpackage

// File: rtl/stopmode_wake_detect.sv
module stopmode_wake_detect #(
    parameter int LVL_W = 3
) (
    input  logic [LVL_W-1:0] irq_level,
    input  logic             ext_reset_req,
    output logic             irq_pending,
    output logic             wake_any,
    output logic             wake_is_rst
);
    localparam logic [LVL_W-1:0] LVL_NONE = '1;

    always_comb begin
        irq_pending = (irq_level != LVL_NONE);
        wake_any    = irq_pending || ext_reset_req;
        wake_is_rst = ext_reset_req;
    end
endmodule

// File: rtl/stopmode_settle_timer.sv
module stopmode_settle_timer
    import stopmode_pkg::*;
#(
    parameter int SHIFT0 = 10,
    parameter int SHIFT1 = 13,
    parameter int SHIFT2 = 15,
    parameter int SHIFT3 = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [SEL_W-1:0] sel,
    output logic             done
);
    localparam int NCODE = 1 << SEL_W;
    localparam int MAX01 = (SHIFT0 > SHIFT1) ? SHIFT0 : SHIFT1;
    localparam int MAX23 = (SHIFT2 > SHIFT3) ? SHIFT2 : SHIFT3;
    localparam int MAXSH = (MAX01 > MAX23) ? MAX01 : MAX23;
    localparam int CNT_W = MAXSH + 1;
    localparam int SH [NCODE] = '{SHIFT0, SHIFT1, SHIFT2, SHIFT3};

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic [CNT_W-1:0] term [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_term
        assign term[g] = (CNT_W'(1) << SH[g]) - CNT_W'(1);
    end

    // The select is frozen while counting, so a mid-wait change is ignored.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (!run) begin
            cnt_q <= '0;
            sel_q <= sel;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

    assign done = run && (cnt_q == term[sel_q]);
endmodule

// File: rtl/stopmode_ctl.sv
module stopmode_ctl
    import stopmode_pkg::*;
#(
    parameter int LVL_W  = 3,
    parameter int SHIFT0 = 10,
    parameter int SHIFT1 = 13,
    parameter int SHIFT2 = 15,
    parameter int SHIFT3 = 17
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_wr,
    input  logic             ctl_stop_bit,
    input  logic             ctl_pin_hiz_bit,
    input  logic [1:0]       wait_sel,
    input  logic [LVL_W-1:0] irq_level,
    input  logic             ext_reset_req,
    input  logic             hold_req,
    output logic             osc_en,
    output logic             core_clk_en,
    output logic             pin_hiz,
    output logic             hold_ack,
    output logic             wake_irq,
    output logic             reset_seq_start,
    output logic             stop_bit,
    output logic [1:0]       status
);
    stop_state_e state_q, state_d;
    logic irq_pending, wake_any, wake_is_rst, settle_done;
    logic accept_stop;
    logic hiz_q, stop_q, cause_rst_q, hold_q;

    stopmode_wake_detect #(.LVL_W(LVL_W)) u_wake (
        .irq_level     (irq_level),
        .ext_reset_req (ext_reset_req),
        .irq_pending   (irq_pending),
        .wake_any      (wake_any),
        .wake_is_rst   (wake_is_rst)
    );

    stopmode_settle_timer #(
        .SHIFT0(SHIFT0), .SHIFT1(SHIFT1), .SHIFT2(SHIFT2), .SHIFT3(SHIFT3)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == ST_SETTLE),
        .sel   (wait_sel),
        .done  (settle_done)
    );

    assign accept_stop = (state_q == ST_RUN) && ctl_wr && ctl_stop_bit && !irq_pending;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:      if (accept_stop) state_d = ST_STOPPING;
            ST_STOPPING: state_d = wake_any ? ST_SETTLE : ST_STOPPED;
            ST_STOPPED:  if (wake_any) state_d = ST_SETTLE;
            ST_SETTLE:   if (settle_done) state_d = ST_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_d;
    end

    // Captured control bits and wake cause
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hiz_q       <= 1'b0;
            stop_q      <= 1'b0;
            cause_rst_q <= 1'b0;
            hold_q      <= 1'b0;
        end else begin
            hold_q <= hold_req && (state_q == ST_RUN);
            if (accept_stop) begin
                hiz_q  <= ctl_pin_hiz_bit;
                stop_q <= 1'b1;
            end
            if ((state_q == ST_SETTLE) && settle_done) stop_q <= 1'b0;
            if (((state_q == ST_STOPPING) || (state_q == ST_STOPPED)) && wake_any)
                cause_rst_q <= wake_is_rst;
            else if ((state_q == ST_SETTLE) && ext_reset_req)
                cause_rst_q <= 1'b1;
        end
    end

    // Outputs decoded from state
    always_comb begin
        osc_en          = 1'b1;
        core_clk_en     = 1'b0;
        pin_hiz         = hiz_q;
        hold_ack        = 1'b0;
        wake_irq        = 1'b0;
        reset_seq_start = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                core_clk_en = 1'b1;
                pin_hiz     = 1'b0;
                hold_ack    = hold_q;
            end
            ST_STOPPING: ;
            ST_STOPPED:  osc_en = 1'b0;
            ST_SETTLE: begin
                reset_seq_start = settle_done && (cause_rst_q || ext_reset_req);
                wake_irq        = settle_done && !(cause_rst_q || ext_reset_req);
            end
        endcase
        stop_bit = stop_q;
        status   = state_q;
    end
endmodule

// File: rtl/stopmode_ctl_checker.sv
module stopmode_ctl_checker #(
    parameter int LVL_W = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             ctl_wr,
    input logic             ctl_stop_bit,
    input logic [LVL_W-1:0] irq_level,
    input logic             ext_reset_req,
    input logic             osc_en,
    input logic             core_clk_en,
    input logic             pin_hiz,
    input logic             hold_ack,
    input logic             wake_irq,
    input logic             reset_seq_start,
    input logic             stop_bit,
    input logic [1:0]       status
);
    localparam logic [LVL_W-1:0] NONE = '1;

    assert_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00 && ctl_wr && ctl_stop_bit && irq_level == NONE) |=> status == 2'b01);

    assert_osc_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10) |-> (!osc_en && !core_clk_en));

    assert_entry_blocked_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00 && ctl_wr && ctl_stop_bit && irq_level != NONE) |=> status == 2'b00);

    assert_pins_driven_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b00) |-> !pin_hiz);

    assert_no_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (status != 2'b00) |-> !hold_ack);

    assert_level7_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && irq_level == NONE && !ext_reset_req) |=> status == 2'b10);

    assert_wake_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status == 2'b10 && (irq_level != NONE || ext_reset_req))
        |=> (status == 2'b11 && osc_en && !core_clk_en));

    assert_clk_after_settle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(core_clk_en) |-> $past(wake_irq || reset_seq_start));

    assert_one_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wake_irq, reset_seq_start}));

    assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq || reset_seq_start) |=> (status == 2'b00 && core_clk_en && !stop_bit));
endmodule

bind stopmode_ctl stopmode_ctl_checker #(.LVL_W(LVL_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .ctl_wr          (ctl_wr),
    .ctl_stop_bit    (ctl_stop_bit),
    .irq_level       (irq_level),
    .ext_reset_req   (ext_reset_req),
    .osc_en          (osc_en),
    .core_clk_en     (core_clk_en),
    .pin_hiz         (pin_hiz),
    .hold_ack        (hold_ack),
    .wake_irq        (wake_irq),
    .reset_seq_start (reset_seq_start),
    .stop_bit        (stop_bit),
    .status          (status)
);

// File: tb/stopmode_ctl_test.sv
`timescale 1ns/1ps
module stopmode_ctl_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_wr = 1'b0, ctl_stop_bit = 1'b0, ctl_pin_hiz_bit = 1'b0;
    logic [1:0] wait_sel = 2'd0;
    logic [2:0] irq_level = 3'd7;
    logic       ext_reset_req = 1'b0, hold_req = 1'b0;
    logic       osc_en, core_clk_en, pin_hiz, hold_ack, wake_irq, reset_seq_start, stop_bit;
    logic [1:0] status;

    int n_checks = 0;
    int n_errs   = 0;
    int settle_cnt = 0;

    typedef struct { bit is_rst; int len; } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    stopmode_ctl #(.SHIFT0(2), .SHIFT1(3), .SHIFT2(4), .SHIFT3(5)) uut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_stop_bit(ctl_stop_bit),
        .ctl_pin_hiz_bit(ctl_pin_hiz_bit), .wait_sel(wait_sel), .irq_level(irq_level),
        .ext_reset_req(ext_reset_req), .hold_req(hold_req), .osc_en(osc_en),
        .core_clk_en(core_clk_en), .pin_hiz(pin_hiz), .hold_ack(hold_ack),
        .wake_irq(wake_irq), .reset_seq_start(reset_seq_start), .stop_bit(stop_bit),
        .status(status)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #1;
        end
    endtask

    task automatic wr(input bit stp, input bit hiz);
        ctl_wr = 1'b1; ctl_stop_bit = stp; ctl_pin_hiz_bit = hiz;
        step();
        ctl_wr = 1'b0; ctl_stop_bit = 1'b0; ctl_pin_hiz_bit = 1'b0;
    endtask

    task automatic enter_stop(input bit hiz, input logic [1:0] sel);
        wait_sel = sel;
        wr(1'b1, hiz);
        step();
        chk(status == 2'b10, "R2 reach STOPPED", status, 2);
    endtask

    task automatic wait_run();
        for (int i = 0; i < 200 && status != 2'b00; i++) step();
    endtask

    // Scoreboard monitor: counts SETTLE cycles and matches wake pulses.
    always @(posedge clk) begin
        #2;
        if (rst_n) begin
            if (status == 2'b11) settle_cnt++;
            if (wake_irq || reset_seq_start) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R9/R10 unexpected wake pulse", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(reset_seq_start == e.is_rst,
                        e.is_rst ? "R9 reset cause" : "R10 irq cause",
                        reset_seq_start, e.is_rst);
                    chk(settle_cnt == e.len, "R8 settle length", settle_cnt, e.len);
                end
            end
            if (status != 2'b11) settle_cnt = 0;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_errs++;
        n_checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end

    initial begin
        step(2);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk(status == 2'b00 && osc_en && core_clk_en && !pin_hiz && !hold_ack && !stop_bit
            && !wake_irq && !reset_seq_start, "R1 reset state", status, 0);

        // R11 write without stop bit
        wr(1'b0, 1'b1);
        chk(status == 2'b00 && !pin_hiz, "R11 write stop=0", status, 0);

        // R3 pending interrupt blocks entry
        irq_level = 3'd2;
        wr(1'b1, 1'b0);
        chk(status == 2'b00 && !stop_bit, "R3 entry refused", status, 0);
        irq_level = 3'd7;

        // R5 hold in RUN
        hold_req = 1'b1;
        step();
        chk(hold_ack == 1'b1, "R5 hold ack in RUN", hold_ack, 1);

        // R2 entry, pins floating
        wait_sel = 2'd0;
        wr(1'b1, 1'b1);
        chk(status == 2'b01 && !core_clk_en && stop_bit, "R2 STOPPING", status, 1);
        step();
        chk(status == 2'b10 && !osc_en, "R2 STOPPED osc off", osc_en, 0);
        chk(pin_hiz == 1'b1, "R4 pins float", pin_hiz, 1);
        chk(hold_ack == 1'b0, "R5 hold ignored", hold_ack, 0);

        // R11 write outside RUN ignored
        wr(1'b1, 1'b0);
        chk(status == 2'b10 && pin_hiz, "R11 write while stopped", pin_hiz, 1);

        // R6 level 7 does not wake
        step(5);
        chk(status == 2'b10, "R6 level 7 stays stopped", status, 2);

        // R7/R10 interrupt wake, code 0 -> 4 cycles
        exp_q.push_back('{1'b0, 4});
        irq_level = 3'd3;
        step();
        chk(status == 2'b11 && osc_en && !core_clk_en, "R7 SETTLE", status, 3);
        irq_level = 3'd7;
        wait_run();
        chk(core_clk_en && !stop_bit, "R10 clock released", core_clk_en, 1);
        step();
        chk(hold_ack == 1'b1, "R5 hold resumes", hold_ack, 1);
        hold_req = 1'b0;

        // R9 reset wake, code 1 -> 8, pins held
        enter_stop(1'b0, 2'd1);
        chk(pin_hiz == 1'b0, "R4 pins held", pin_hiz, 0);
        exp_q.push_back('{1'b1, 8});
        ext_reset_req = 1'b1;
        step();
        ext_reset_req = 1'b0;
        chk(status == 2'b11, "R7 reset wake", status, 3);
        wait_run();

        // R9 reset and interrupt together, code 2 -> 16
        enter_stop(1'b0, 2'd2);
        exp_q.push_back('{1'b1, 16});
        ext_reset_req = 1'b1; irq_level = 3'd0;
        step();
        ext_reset_req = 1'b0; irq_level = 3'd7;
        wait_run();

        // R9 reset during settle upgrades cause, code 3 -> 32
        enter_stop(1'b1, 2'd3);
        exp_q.push_back('{1'b1, 32});
        irq_level = 3'd5;
        step();
        irq_level = 3'd7;
        step(5);
        ext_reset_req = 1'b1;
        step();
        ext_reset_req = 1'b0;
        wait_run();

        // R8 select change during settle ignored
        enter_stop(1'b0, 2'd0);
        exp_q.push_back('{1'b0, 4});
        irq_level = 3'd1;
        step();
        irq_level = 3'd7;
        wait_sel = 2'd3;
        wait_run();

        step(3);
        chk(exp_q.size() == 0, "R8 all wakes seen", exp_q.size(), 0);
        chk(status == 2'b00, "R10 final RUN", status, 0);
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule